// File: doc/BRIEF.md
# Compressed-Mode Exception Resume Resolver

When a processor running its 16-bit compressed instruction mode takes an exception, the handler must know where execution resumes and whether the faulting instruction still owes a write to the link register. This block works that out. It takes the faulting PC, the first two fetched halfwords and the register-file values it may need: the link register and one source register whose index the block itself names. One cycle after a request strobe it presents the resume PC, an optional link-register write, or a fault flag if the fetch of the instruction failed.

Four shapes are recognised. The first is a prefix that widens the next instruction. The second is a 32-bit jump-and-link whose 26-bit target is spread over three fields of the two halfwords, and which can switch instruction mode. The third is the register-indirect jump family, with optional link and an optional empty delay slot. Everything else simply steps over one halfword. The opcode is `hw0[15:11]`.

Top module: `cx_resume_resolver`

## Requirements
- R1: After reset, `res_valid`, `link_we` and `fault` are 0 and `res_pc` and `link_data` are zero.
- R2: Each cycle with `req_valid` high produces `res_valid` high in the next cycle only; with no request, `res_valid` stays low.
- R3: Opcode `11110` (width prefix) resumes at PC+4 and writes no link.
- R4: Opcode `00011` (long jump-and-link) forms the word W = {hw0, hw1}. The resume PC takes bits [XLEN-1:28] from PC+4. Bits [27:23] are W[20:16], bits [22:18] are W[25:21], bits [17:2] are W[15:0] and bit 1 is 0.
- R5: For the long jump-and-link, resume PC bit 0 is 1 when the exchange bit `hw0[10]` is 0 (stay compressed) and 0 when it is 1.
- R6: The long jump-and-link writes the link with PC+6 (`link_we`=1).
- R7: Opcode `11101` with `hw0[4:0]`=`00000` is a register jump. If `hw0[5]` is 1 it resumes at `link_val`, otherwise at `src_val`. `src_idx` always shows the mapped register for rx = `hw0[10:8]`: rx 0 and 1 map to 16 and 17, and rx 2 to 7 map to 2 to 7.
- R8: A register jump with link flag `hw0[6]`=1 writes the link with PC+2 when the no-delay flag `hw0[7]` is 1, and with PC+4 when it is 0. With `hw0[6]`=0 there is no link write.
- R9: Every other opcode, including `11101` with nonzero `hw0[4:0]`, resumes at PC+2 with no link write.
- R10: With `fetch_err` high on a request, the result has `fault`=1, `link_we`=0 and `res_pc` equal to the faulting PC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request strobe, one cycle per exception |
| pc | input | XLEN | Faulting PC |
| hw0 | input | 16 | First fetched halfword |
| hw1 | input | 16 | Second fetched halfword |
| fetch_err | input | 1 | Fetch of the instruction failed |
| link_val | input | XLEN | Current link register value |
| src_idx | output | IDX_W | Register index the block wants on `src_val` |
| src_val | input | XLEN | Value of register `src_idx` |
| res_valid | output | 1 | Result valid |
| res_pc | output | XLEN | Resume PC |
| link_we | output | 1 | Link register write enable |
| link_data | output | XLEN | Value to write to the link register |
| fault | output | 1 | Request hit a fetch error |

## Verification
`src_idx` is combinational from `hw0`. The bench drives each request on a falling edge and reads `src_idx` one time step later, before the capturing edge. All registered results (`res_valid`, `res_pc`, `link_we`, `link_data`, `fault`) are due exactly one rising edge after the request. They are read on the following falling edge. One edge later, `res_valid` is read again to confirm that it has dropped. Each request is held for exactly one cycle, so no result can be mistaken for a neighbour's.

// File: rtl/cxr_pkg.sv
package cxr_pkg;
   localparam int HW_W = 16;
   localparam int OPC_W = 5;

   localparam logic [OPC_W-1:0] OPC_WIDEN = 5'b11110;
   localparam logic [OPC_W-1:0] OPC_LJAL  = 5'b00011;
   localparam logic [OPC_W-1:0] OPC_RRGRP = 5'b11101;
   localparam logic [4:0]       FN_RJUMP  = 5'b00000;

   typedef enum logic [1:0] {
      K_STEP  = 2'd0,
      K_WIDEN = 2'd1,
      K_LJAL  = 2'd2,
      K_RJMP  = 2'd3
   } insn_kind_e;

   typedef struct packed {
      insn_kind_e kind;
      logic       xchg;
      logic       use_ra;
      logic       do_link;
      logic       no_dly;
      logic [2:0] rx;
   } dec_t;
endpackage

// File: rtl/cxr_decode.sv
module cxr_decode
   import cxr_pkg::*;
(
   input  logic [HW_W-1:0] hw0,
   output dec_t            dec
);
   logic [OPC_W-1:0] opc;
   assign opc = hw0[HW_W-1 -: OPC_W];

   always_comb begin
      dec         = '0;
      dec.kind    = K_STEP;
      dec.rx      = hw0[10:8];
      dec.xchg    = hw0[10];
      dec.no_dly  = hw0[7];
      dec.do_link = hw0[6];
      dec.use_ra  = hw0[5];
      case (opc)
         OPC_WIDEN: dec.kind = K_WIDEN;
         OPC_LJAL:  dec.kind = K_LJAL;
         OPC_RRGRP: if (hw0[4:0] == FN_RJUMP) dec.kind = K_RJMP;
         default:   dec.kind = K_STEP;
      endcase
   end
endmodule

// File: rtl/cxr_jal_target.sv
module cxr_jal_target
   import cxr_pkg::*;
#(
   parameter int XLEN = 32
) (
   input  logic [XLEN-1:0] pc_plus4,
   input  logic [HW_W-1:0] hw0,
   input  logic [HW_W-1:0] hw1,
   output logic [XLEN-1:0] target
);
   localparam int REGION_LSB = 28;
   logic [2*HW_W-1:0] word;
   assign word = {hw0, hw1};

   always_comb begin
      target = '0;
      target[XLEN-1:REGION_LSB] = pc_plus4[XLEN-1:REGION_LSB];
      target[27:23] = word[20:16];
      target[22:18] = word[25:21];
      target[17:2]  = word[15:0];
      target[1]     = 1'b0;
      target[0]     = ~word[26];
   end
endmodule

// File: rtl/cxr_reg_map.sv
module cxr_reg_map #(
   parameter int IDX_W     = 5,
   parameter int BANK_BASE = 16
) (
   input  logic [2:0]       code,
   output logic [IDX_W-1:0] idx
);
   localparam int NCODE = 8;
   logic [NCODE-1:0][IDX_W-1:0] contrib;

   for (genvar c = 0; c < NCODE; c++) begin : g_code
      localparam int MAPPED = (c < 2) ? (BANK_BASE + c) : c;
      assign contrib[c] = (code == 3'(c)) ? IDX_W'(MAPPED) : '0;
   end

   always_comb begin
      idx = '0;
      for (int c = 0; c < NCODE; c++) idx = idx | contrib[c];
   end
endmodule

// File: rtl/cx_resume_resolver.sv
module cx_resume_resolver
   import cxr_pkg::*;
#(
   parameter int XLEN      = 32,
   parameter int IDX_W     = 5,
   parameter int BANK_BASE = 16
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             req_valid,
   input  logic [XLEN-1:0]  pc,
   input  logic [15:0]      hw0,
   input  logic [15:0]      hw1,
   input  logic             fetch_err,
   input  logic [XLEN-1:0]  link_val,
   output logic [IDX_W-1:0] src_idx,
   input  logic [XLEN-1:0]  src_val,
   output logic             res_valid,
   output logic [XLEN-1:0]  res_pc,
   output logic             link_we,
   output logic [XLEN-1:0]  link_data,
   output logic             fault
);
   if (XLEN < 32 || (XLEN % HW_W) != 0) begin : g_bad_xlen
      $error("cx_resume_resolver: XLEN must be a multiple of 16 and at least 32");
   end
   if (BANK_BASE + 1 >= (1 << IDX_W) || BANK_BASE < 8) begin : g_bad_bank
      $error("cx_resume_resolver: BANK_BASE must lie above 7 and fit IDX_W");
   end

   localparam logic [XLEN-1:0] STEP1 = XLEN'(2);
   localparam logic [XLEN-1:0] STEP2 = XLEN'(4);
   localparam logic [XLEN-1:0] STEP3 = XLEN'(6);

   dec_t            dec;
   logic [XLEN-1:0] pc_p2, pc_p4, pc_p6, jal_tgt;
   logic [XLEN-1:0] nxt_pc, nxt_link;
   logic            nxt_we;

   assign pc_p2 = pc + STEP1;
   assign pc_p4 = pc + STEP2;
   assign pc_p6 = pc + STEP3;

   cxr_decode u_dec (.hw0(hw0), .dec(dec));

   cxr_jal_target #(.XLEN(XLEN)) u_tgt (
      .pc_plus4(pc_p4), .hw0(hw0), .hw1(hw1), .target(jal_tgt)
   );

   cxr_reg_map #(.IDX_W(IDX_W), .BANK_BASE(BANK_BASE)) u_map (
      .code(dec.rx), .idx(src_idx)
   );

   always_comb begin
      nxt_pc   = pc_p2;
      nxt_we   = 1'b0;
      nxt_link = '0;
      case (dec.kind)
         K_WIDEN: nxt_pc = pc_p4;
         K_LJAL: begin
            nxt_pc   = jal_tgt;
            nxt_we   = 1'b1;
            nxt_link = pc_p6;
         end
         K_RJMP: begin
            nxt_pc = dec.use_ra ? link_val : src_val;
            if (dec.do_link) begin
               nxt_we   = 1'b1;
               nxt_link = dec.no_dly ? pc_p2 : pc_p4;
            end
         end
         default: nxt_pc = pc_p2;
      endcase
      if (fetch_err) begin
         nxt_pc   = pc;
         nxt_we   = 1'b0;
         nxt_link = '0;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         res_valid <= 1'b0;
         res_pc    <= '0;
         link_we   <= 1'b0;
         link_data <= '0;
         fault     <= 1'b0;
      end else begin
         res_valid <= req_valid;
         link_we   <= req_valid & nxt_we;
         fault     <= req_valid & fetch_err;
         if (req_valid) begin
            res_pc    <= nxt_pc;
            link_data <= nxt_link;
         end
      end
   end
endmodule

// File: rtl/cxr_resolver_chk.sv
module cxr_resolver_chk
   import cxr_pkg::*;
#(
   parameter int XLEN  = 32,
   parameter int IDX_W = 5
) (
   input logic             clk,
   input logic             rst_n,
   input logic             req_valid,
   input logic [XLEN-1:0]  pc,
   input logic [15:0]      hw0,
   input logic             fetch_err,
   input logic [IDX_W-1:0] src_idx,
   input logic             res_valid,
   input logic [XLEN-1:0]  res_pc,
   input logic             link_we,
   input logic [XLEN-1:0]  link_data,
   input logic             fault
);
   // R2
   resp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> res_valid);
   // R2
   no_spurious_resp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !res_valid && !link_we && !fault);
   // R10
   err_blocks_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && fetch_err |=> fault && !link_we && res_pc == $past(pc));
   // R3
   widen_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !fetch_err && hw0[15:11] == OPC_WIDEN
      |=> res_pc == $past(pc) + XLEN'(4) && !link_we);
   // R6
   ljal_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !fetch_err && hw0[15:11] == OPC_LJAL
      |=> link_we && link_data == $past(pc) + XLEN'(6));
   // R5
   ljal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid && !fetch_err && hw0[15:11] == OPC_LJAL
      |=> res_pc[0] == !$past(hw0[10]));
   // R7
   rx_bank_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (hw0[10:9] == 2'b00) == (src_idx > IDX_W'(7)));
endmodule

bind cx_resume_resolver cxr_resolver_chk #(.XLEN(XLEN), .IDX_W(IDX_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pc(pc), .hw0(hw0),
   .fetch_err(fetch_err), .src_idx(src_idx), .res_valid(res_valid),
   .res_pc(res_pc), .link_we(link_we), .link_data(link_data), .fault(fault)
);

// File: tb/cx_resume_resolver_bench.sv
module cx_resume_resolver_bench;
   localparam int CLK_PERIOD = 10;
   localparam int XLEN = 32;
   localparam int IDX_W = 5;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [XLEN-1:0] pc = '0;
   logic [15:0] hw0 = '0, hw1 = '0;
   logic fetch_err = 1'b0;
   logic [XLEN-1:0] link_val = 32'hA5C3_0E10;
   logic [XLEN-1:0] src_val = '0;
   logic [IDX_W-1:0] src_idx;
   logic res_valid, link_we, fault;
   logic [XLEN-1:0] res_pc, link_data;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   cx_resume_resolver u_cx_resume_resolver (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .pc(pc), .hw0(hw0),
      .hw1(hw1), .fetch_err(fetch_err), .link_val(link_val),
      .src_idx(src_idx), .src_val(src_val), .res_valid(res_valid),
      .res_pc(res_pc), .link_we(link_we), .link_data(link_data), .fault(fault)
   );

   task automatic chk(string req, logic [XLEN-1:0] act, logic [XLEN-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%h expected=%h (pc=%h hw0=%h hw1=%h)",
                  req, act, exp, pc, hw0, hw1);
      end
   endtask

   function automatic logic [4:0] map_rx(logic [2:0] rx);
      return (rx < 3'd2) ? 5'(16 + rx) : 5'(rx);
   endfunction

   function automatic logic [XLEN-1:0] reg_value(logic [4:0] idx);
      return 32'h4000_2468 + (32'(idx) << 16);
   endfunction

   task automatic run(logic [XLEN-1:0] p, logic [15:0] a, logic [15:0] b, logic err);
      logic [XLEN-1:0] e_pc, e_ld, w;
      logic e_we;
      string tag;
      @(negedge clk);
      pc = p; hw0 = a; hw1 = b; fetch_err = err;
      src_val = reg_value(map_rx(a[10:8]));
      req_valid = 1'b1;
      w = {a, b};
      e_we = 1'b0; e_ld = 'x; e_pc = p + 2; tag = "R9";
      if (a[15:11] == 5'b11110) begin
         e_pc = p + 4; tag = "R3";
      end else if (a[15:11] == 5'b00011) begin
         e_pc = ((p + 4) & 32'hF000_0000) | ((w & 32'hFFFF) << 2)
              | ((w & 32'h03E0_0000) >> 3) | ((w & 32'h001F_0000) << 7)
              | (a[10] ? 32'd0 : 32'd1);
         e_we = 1'b1; e_ld = p + 6; tag = "R4/R5/R6";
      end else if (a[15:11] == 5'b11101 && a[4:0] == 5'd0) begin
         e_pc = a[5] ? link_val : reg_value(map_rx(a[10:8]));
         tag = "R7/R8";
         if (a[6]) begin
            e_we = 1'b1; e_ld = a[7] ? p + 2 : p + 4;
         end
      end
      if (err) begin
         e_pc = p; e_we = 1'b0; tag = "R10";
      end
      #1;
      // R7 index mapping is combinational
      chk("R7 src_idx", 32'(src_idx), 32'(map_rx(a[10:8])));
      @(negedge clk);
      chk({"R2 res_valid ", tag}, 32'(res_valid), 32'd1);
      chk({tag, " res_pc"}, res_pc, e_pc);
      chk({tag, " link_we"}, 32'(link_we), 32'(e_we));
      chk({"R10 fault ", tag}, 32'(fault), 32'(err));
      if (e_we) chk({tag, " link_data"}, link_data, e_ld);
      req_valid = 1'b0;
      @(negedge clk);
      chk("R2 res_valid drops", 32'(res_valid), 32'd0);
      chk("R2 link_we drops", 32'(link_we), 32'd0);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1 res_valid", 32'(res_valid), 32'd0);
      chk("R1 link_we", 32'(link_we), 32'd0);
      chk("R1 fault", 32'(fault), 32'd0);
      chk("R1 res_pc", res_pc, 32'd0);
      chk("R1 link_data", link_data, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      chk("R2 idle", 32'(res_valid), 32'd0);

      // R3 R9: every opcode with two operand patterns
      for (int op = 0; op < 32; op++) begin
         run(32'h0040_1000 + 32'(op) * 4, {5'(op), 11'h5A3}, 16'h1234, 1'b0);
         run(32'h0077_FFF0, {5'(op), 11'h000}, 16'hFFFF, 1'b0);
      end

      // R4 R5 R6: long jump-and-link, both exchange values, region boundary
      for (int x = 0; x < 2; x++) begin
         for (int i = 0; i < 8; i++) begin
            logic [9:0] f = 10'(i * 32'h73 + 32'h2A5);
            logic [15:0] lo = 16'(i * 32'h1F3D + 32'h8001);
            run(32'h0FFF_FFFC, {5'b00011, 1'(x), f}, lo, 1'b0);
            run(32'h8000_0100 + 32'(i) * 2, {5'b00011, 1'(x), f}, lo, 1'b0);
         end
      end

      // R7 R8: full sweep of register-jump flags and rx codes
      for (int rx = 0; rx < 8; rx++)
         for (int fl = 0; fl < 8; fl++)
            run(32'h2000_0200 + 32'(rx) * 16, {5'b11101, 3'(rx), 3'(fl), 5'd0},
                16'h0, 1'b0);

      // R9: register group with other function codes
      for (int fn = 1; fn < 32; fn += 5)
         run(32'h0000_3000, {5'b11101, 3'd3, 3'b111, 5'(fn)}, 16'h0, 1'b0);

      // R10: fetch error on each decoded shape
      run(32'h1234_5678, {5'b11110, 11'h0}, 16'h0, 1'b1);
      run(32'h1234_567A, {5'b00011, 11'h3FF}, 16'hFFFF, 1'b1);
      run(32'h1234_567C, {5'b11101, 3'd1, 3'b010, 5'd0}, 16'h0, 1'b1);
      run(32'h1234_567E, {5'b01000, 11'h1}, 16'h0, 1'b1);

      if (!done) begin
         done = 1;
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++; errors++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end
endmodule